// File: doc/BRIEF.md
# Tagged Transmit Queue Pair with Write-Address Commit

This block sits between a host register window and the transmit side of a serial-bus link layer. It holds outgoing packets as 32-bit quadlets in two queues: one for asynchronous traffic and one for isochronous traffic. The host writes one quadlet per strobe. The offset of the write picks the queue and also picks the role of the quadlet: packet start, packet middle, or a write that also commits everything stored so far. Every entry is kept as 33 bits. Bit 32 is a tag that is 1 on the first quadlet of a packet and 0 on the others. The transmitter sees only committed quadlets, so a packet that is half written never starts going out early.

The transmit side takes `{tag, quadlet}` words through a valid/ready handshake. The block tracks whether the transmitter is part-way through a packet. If the transmitter asks for a quadlet in the middle of a packet and nothing committed is left, that is an underflow. On the asynchronous queue an underflow is only reported. On the isochronous queue an underflow, or a packet that did not open at the start offset, puts the queue into a sticky fault state. The fault state stops isochronous output until a clear control input flushes that queue. Asynchronous output keeps running during the fault. The first commit into an isochronous queue that holds nothing committed sends a one-cycle request for bus arbitration.

Top module: `txq_commit_fifo`

## Requirements
- R1: An asynchronous write at offset 80h stores the quadlet with tag 1, and a write at 84h stores it with tag 0. Neither write commits, so `a_valid` stays low while only such writes are stored.
- R2: A write at 8Ch stores the quadlet with tag 0 and commits every stored asynchronous quadlet. `a_valid` rises in the cycle after the write edge. Back-to-back 8Ch writes each commit.
- R3: A run of writes at A0h on consecutive cycles stores the first quadlet of the run with tag 1 and the rest with tag 0. Each write in the run commits at once.
- R4: Each queue hands out words in write order as `{tag, quadlet}`, with the tag at bit 32. A word is removed on a clock edge where valid and ready are both high. While ready is low, the head word and valid stay unchanged.
- R5: Suppose the transmitter has taken a word and the next stored word has tag 0. If ready is then high while nothing committed remains, `a_underflow` pulses for one cycle after that edge.
- R6: Isochronous offsets 90h, 94h and 9Ch store with tag 1, tag 0, and tag 0 with commit. They follow the same visibility rule as R1 and R2.
- R7: If the first isochronous write after reset or clear is not at 90h, `i_bad` sets and stays set, and `i_bad_irq` pulses for one cycle. Both are visible after the write edge.
- R8: An isochronous underflow, under the same condition as R5, also sets `i_bad` and pulses `i_bad_irq`.
- R9: While `i_bad` is set, `i_valid` is low even if committed data is present. The asynchronous queue keeps working.
- R10: `clr_iso` high for one edge empties the isochronous queue, clears `i_bad`, and re-arms the start-offset check. After that edge `i_valid` and `i_bad` are low.
- R11: An isochronous commit while the queue holds no committed quadlet pulses `arb_req` for the one cycle after the write edge. A commit while committed data is present gives no pulse. The empty condition returns when the last committed word is taken, and after reset or clear.
- R12: Each queue holds at most 32 quadlets. A write into a full queue is dropped, but a commit carried by that write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write offset |
| wr_data | input | 32 | Host write quadlet |
| clr_iso | input | 1 | Flush isochronous queue and its fault state |
| a_ready | input | 1 | Transmitter wants an asynchronous word |
| a_valid | output | 1 | Committed asynchronous word available |
| a_quad | output | 33 | Asynchronous head word {tag, quadlet} |
| a_underflow | output | 1 | Asynchronous underflow pulse |
| i_ready | input | 1 | Transmitter wants an isochronous word |
| i_valid | output | 1 | Committed isochronous word available and no fault |
| i_quad | output | 33 | Isochronous head word {tag, quadlet} |
| i_bad | output | 1 | Sticky isochronous fault state |
| i_bad_irq | output | 1 | One-cycle pulse on entry to the fault state |
| arb_req | output | 1 | One-cycle bus arbitration request |

## Verification
Each result from a write or a pop is registered once, so it is due in the cycle after the edge that caught the stimulus. This covers commit visibility, the underflow and fault pulses, the arbitration pulse, and the clear. Inputs are driven on the falling edge and held across exactly one rising edge. Each check samples one time step after the next falling edge, which is the first settled point after the edge that caused the result. Pulse outputs are checked again one cycle later to show they lasted only one cycle. The head word is compared before the edge that removes it.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int QUAD_W = 32;

  localparam logic [15:0] OFS_A_OPEN  = 16'h0080;
  localparam logic [15:0] OFS_A_MID   = 16'h0084;
  localparam logic [15:0] OFS_A_SEAL  = 16'h008C;
  localparam logic [15:0] OFS_I_OPEN  = 16'h0090;
  localparam logic [15:0] OFS_I_MID   = 16'h0094;
  localparam logic [15:0] OFS_I_SEAL  = 16'h009C;
  localparam logic [15:0] OFS_A_BURST = 16'h00A0;

  typedef enum logic [2:0] {
    WK_NONE, WK_A_OPEN, WK_A_MID, WK_A_SEAL, WK_A_BURST,
    WK_I_OPEN, WK_I_MID, WK_I_SEAL
  } wkind_e;

  function automatic wkind_e classify(input logic [15:0] ofs);
    case (ofs)
      OFS_A_OPEN:  return WK_A_OPEN;
      OFS_A_MID:   return WK_A_MID;
      OFS_A_SEAL:  return WK_A_SEAL;
      OFS_A_BURST: return WK_A_BURST;
      OFS_I_OPEN:  return WK_I_OPEN;
      OFS_I_MID:   return WK_I_MID;
      OFS_I_SEAL:  return WK_I_SEAL;
      default:     return WK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/txq_wr_decode.sv
module txq_wr_decode
  import txq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              a_push,
  output logic              a_tag,
  output logic              a_commit,
  output logic              i_open,
  output logic              i_mid,
  output logic              i_seal
);
  wkind_e kind;
  logic   burst_hit;
  logic   burst_prev_q;

  always_comb begin
    kind      = wr_en ? classify(16'(wr_addr)) : WK_NONE;
    burst_hit = (kind == WK_A_BURST);
    a_push    = (kind == WK_A_OPEN) || (kind == WK_A_MID) ||
                (kind == WK_A_SEAL) || burst_hit;
    a_tag     = (kind == WK_A_OPEN) || (burst_hit && !burst_prev_q);
    a_commit  = (kind == WK_A_SEAL) || burst_hit;
    i_open    = (kind == WK_I_OPEN);
    i_mid     = (kind == WK_I_MID);
    i_seal    = (kind == WK_I_SEAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) burst_prev_q <= 1'b0;
    else        burst_prev_q <= burst_hit;
  end
endmodule

// File: rtl/txq_tag_fifo.sv
module txq_tag_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic            push_tag,
  input  logic [DATA_W-1:0] push_data,
  input  logic            commit,
  input  logic            take,
  input  logic            want,
  output logic            avail,
  output logic [DATA_W:0] head,
  output logic [CW-1:0]   occ,
  output logic [CW-1:0]   committed,
  output logic            starve
);
  logic [DATA_W:0] mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr, rd_nxt;
  logic [CW-1:0]   cnt_q, ccnt_q, cnt_nx;
  logic            in_pkt_q, push_ok, more_follow;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] count_next(input logic [CW-1:0] c,
                                               input logic up, input logic dn);
    return c + CW'(up) - CW'(dn);
  endfunction

  always_comb begin
    push_ok     = push && ((cnt_q != CW'(DEPTH)) || take);
    cnt_nx      = count_next(cnt_q, push_ok, take);
    rd_nxt      = step(rd_ptr);
    more_follow = (cnt_q > CW'(1)) ? !mem[rd_nxt][DATA_W] : (push_ok && !push_tag);
    avail       = (ccnt_q != '0);
    head        = mem[rd_ptr];
    occ         = cnt_q;
    committed   = ccnt_q;
    starve      = want && in_pkt_q && !avail;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= {push_tag, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt_q <= '0; ccnt_q <= '0; in_pkt_q <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt_q <= '0; ccnt_q <= '0; in_pkt_q <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (take)    rd_ptr <= rd_nxt;
      cnt_q  <= cnt_nx;
      ccnt_q <= commit ? cnt_nx : count_next(ccnt_q, 1'b0, take);
      if (take) in_pkt_q <= more_follow;
    end
  end
endmodule

// File: rtl/txq_commit_fifo.sv
module txq_commit_fifo
  import txq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 8,
  localparam int DW    = QUAD_W,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              clr_iso,
  input  logic              a_ready,
  output logic              a_valid,
  output logic [DW:0]       a_quad,
  output logic              a_underflow,
  input  logic              i_ready,
  output logic              i_valid,
  output logic [DW:0]       i_quad,
  output logic              i_bad,
  output logic              i_bad_irq,
  output logic              arb_req
);
  logic a_push, a_tag, a_commit, i_open_w, i_mid_w, i_seal_w;
  logic a_avail, a_take, a_starve;
  logic i_avail, i_take, i_starve, i_push, i_commit;
  logic misfirst, bad_enter;
  logic [CW-1:0] a_occ, a_ccnt, i_occ, i_ccnt;
  logic open_q, bad_q, irq_q, empty_q, arb_q, a_under_q;

  txq_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .a_push(a_push), .a_tag(a_tag), .a_commit(a_commit),
    .i_open(i_open_w), .i_mid(i_mid_w), .i_seal(i_seal_w)
  );

  always_comb begin
    a_take    = a_ready && a_avail;
    i_valid   = i_avail && !bad_q;
    i_take    = i_ready && i_valid;
    i_push    = (i_open_w || i_mid_w || i_seal_w) && !clr_iso;
    i_commit  = i_seal_w && !clr_iso;
    misfirst  = (i_mid_w || i_seal_w) && !open_q && !clr_iso;
    bad_enter = (misfirst || (i_starve && !clr_iso)) && !bad_q;
  end

  txq_tag_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) u_async_q (
    .clk(clk), .rst_n(rst_n), .clr(1'b0),
    .push(a_push), .push_tag(a_tag), .push_data(wr_data), .commit(a_commit),
    .take(a_take), .want(a_ready), .avail(a_avail), .head(a_quad),
    .occ(a_occ), .committed(a_ccnt), .starve(a_starve)
  );

  txq_tag_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) u_iso_q (
    .clk(clk), .rst_n(rst_n), .clr(clr_iso),
    .push(i_push), .push_tag(i_open_w), .push_data(wr_data), .commit(i_commit),
    .take(i_take), .want(i_ready), .avail(i_avail), .head(i_quad),
    .occ(i_occ), .committed(i_ccnt), .starve(i_starve)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; bad_q <= 1'b0; irq_q <= 1'b0;
      empty_q <= 1'b1; arb_q <= 1'b0; a_under_q <= 1'b0;
    end else begin
      a_under_q <= a_starve;
      irq_q     <= bad_enter;
      arb_q     <= i_commit && empty_q;
      if (clr_iso) begin
        open_q <= 1'b0; bad_q <= 1'b0; empty_q <= 1'b1;
      end else begin
        if (i_open_w)  open_q <= 1'b1;
        if (bad_enter) bad_q  <= 1'b1;
        if (i_commit)                           empty_q <= 1'b0;
        else if (i_take && i_ccnt == CW'(1))    empty_q <= 1'b1;
      end
    end
  end

  assign a_valid     = a_avail;
  assign a_underflow = a_under_q;
  assign i_bad       = bad_q;
  assign i_bad_irq   = irq_q;
  assign arb_req     = arb_q;
endmodule

// File: rtl/txq_commit_fifo_chk.sv
module txq_commit_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_iso,
  input logic          a_ready,
  input logic          a_valid,
  input logic [32:0]   a_quad,
  input logic          a_underflow,
  input logic          i_valid,
  input logic          i_bad,
  input logic          i_bad_irq,
  input logic          arb_req,
  input logic [CW-1:0] a_occ,
  input logic [CW-1:0] i_occ
);
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_ready) |=> (a_valid && $stable(a_quad))); // R4
  AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    a_underflow |-> $past(a_ready && !a_valid)); // R5
  AST_IRQ_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    i_bad_irq |-> (i_bad && !$past(i_bad))); // R7
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    i_bad_irq |=> !i_bad_irq); // R8
  AST_ISO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    i_bad |-> !i_valid); // R9
  AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr_iso |=> (!i_bad && !i_valid)); // R10
  AST_ARB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req |=> !arb_req); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (a_occ <= CW'(DEPTH)) && (i_occ <= CW'(DEPTH))); // R12
endmodule

bind txq_commit_fifo txq_commit_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_iso(clr_iso), .a_ready(a_ready),
  .a_valid(a_valid), .a_quad(a_quad), .a_underflow(a_underflow),
  .i_valid(i_valid), .i_bad(i_bad), .i_bad_irq(i_bad_irq), .arb_req(arb_req),
  .a_occ(a_occ), .i_occ(i_occ)
);

// File: tb/txq_commit_fifo_bench.sv
module txq_commit_fifo_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic clr_iso = 1'b0, a_ready = 1'b0, i_ready = 1'b0;
  logic a_valid, a_underflow, i_valid, i_bad, i_bad_irq, arb_req;
  logic [32:0] a_quad, i_quad;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txq_commit_fifo u_txq_commit_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_iso(clr_iso), .a_ready(a_ready), .a_valid(a_valid), .a_quad(a_quad),
    .a_underflow(a_underflow), .i_ready(i_ready), .i_valid(i_valid), .i_quad(i_quad),
    .i_bad(i_bad), .i_bad_irq(i_bad_irq), .arb_req(arb_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic idle();
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic pop_a(input string req, input logic tag, input logic [31:0] d);
    @(negedge clk); a_ready = 1'b1; #1;
    chk(req, {63'd0, a_valid}, 64'd1);
    chk(req, {31'd0, a_quad}, {31'd0, tag, d});
    @(posedge clk); #1 a_ready = 1'b0;
  endtask

  task automatic pop_i(input string req, input logic tag, input logic [31:0] d);
    @(negedge clk); i_ready = 1'b1; #1;
    chk(req, {63'd0, i_valid}, 64'd1);
    chk(req, {31'd0, i_quad}, {31'd0, tag, d});
    @(posedge clk); #1 i_ready = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R4 reset a_valid", {63'd0, a_valid}, 0);
    chk("R9 reset i_valid", {63'd0, i_valid}, 0);
    chk("R7 reset i_bad", {63'd0, i_bad}, 0);
    chk("R11 reset arb_req", {63'd0, arb_req}, 0);
    chk("R5 reset a_underflow", {63'd0, a_underflow}, 0);
  endtask

  task automatic t_async_seal();
    wr(8'h80, 32'h1111_0001); wr(8'h84, 32'h1111_0002); idle();
    chk("R1 uncommitted hidden", {63'd0, a_valid}, 0);
    wr(8'h8C, 32'h1111_0003); idle();
    chk("R2 commit visible", {63'd0, a_valid}, 1);
    repeat (2) @(negedge clk);
    #1 chk("R4 head held", {31'd0, a_quad}, {31'd0, 1'b1, 32'h1111_0001});
    pop_a("R1 first tag", 1'b1, 32'h1111_0001);
    pop_a("R1 mid tag", 1'b0, 32'h1111_0002);
    pop_a("R2 seal tag", 1'b0, 32'h1111_0003);
    #1 chk("R4 drained", {63'd0, a_valid}, 0);
    wr(8'h80, 32'h2222_0001); idle();
    chk("R1 open alone hidden", {63'd0, a_valid}, 0);
    wr(8'h8C, 32'h2222_0002); idle();
    chk("R2 first seal commits", {63'd0, a_valid}, 1);
    wr(8'h8C, 32'h2222_0003); wr(8'h8C, 32'h2222_0004); idle();
    pop_a("R2 burst seal", 1'b1, 32'h2222_0001);
    pop_a("R2 burst seal", 1'b0, 32'h2222_0002);
    pop_a("R2 burst seal", 1'b0, 32'h2222_0003);
    pop_a("R2 burst seal", 1'b0, 32'h2222_0004);
  endtask

  task automatic t_async_burst();
    wr(8'hA0, 32'h3333_0001); wr(8'hA0, 32'h3333_0002); wr(8'hA0, 32'h3333_0003); idle();
    wr(8'hA0, 32'h3333_0004); wr(8'hA0, 32'h3333_0005); idle();
    pop_a("R3 run start", 1'b1, 32'h3333_0001);
    pop_a("R3 run body", 1'b0, 32'h3333_0002);
    pop_a("R3 run body", 1'b0, 32'h3333_0003);
    pop_a("R3 second run start", 1'b1, 32'h3333_0004);
    pop_a("R3 second run body", 1'b0, 32'h3333_0005);
  endtask

  task automatic t_async_underflow();
    wr(8'h80, 32'h4444_0001); wr(8'h8C, 32'h4444_0002); wr(8'h84, 32'h4444_0003); idle();
    pop_a("R5 pre", 1'b1, 32'h4444_0001);
    pop_a("R5 pre", 1'b0, 32'h4444_0002);
    @(negedge clk); a_ready = 1'b1; @(posedge clk); #1 a_ready = 1'b0;
    @(negedge clk); #1 chk("R5 underflow pulse", {63'd0, a_underflow}, 1);
    @(negedge clk); #1 chk("R5 pulse ends", {63'd0, a_underflow}, 0);
    wr(8'h8C, 32'h4444_0004); idle();
    pop_a("R5 resume", 1'b0, 32'h4444_0003);
    pop_a("R5 resume", 1'b0, 32'h4444_0004);
  endtask

  task automatic t_iso_misfirst();
    wr(8'h9C, 32'h5555_0001); idle();
    chk("R7 bad set", {63'd0, i_bad}, 1);
    chk("R7 irq pulse", {63'd0, i_bad_irq}, 1);
    chk("R9 iso blocked", {63'd0, i_valid}, 0);
    @(negedge clk); #1;
    chk("R7 irq ends", {63'd0, i_bad_irq}, 0);
    chk("R7 bad sticky", {63'd0, i_bad}, 1);
    wr(8'h80, 32'h5555_0002); wr(8'h8C, 32'h5555_0003); idle();
    pop_a("R9 async runs", 1'b1, 32'h5555_0002);
    pop_a("R9 async runs", 1'b0, 32'h5555_0003);
    @(negedge clk); clr_iso = 1'b1;
    @(negedge clk); clr_iso = 1'b0; #1;
    chk("R10 bad cleared", {63'd0, i_bad}, 0);
    chk("R10 flushed", {63'd0, i_valid}, 0);
  endtask

  task automatic t_iso_basic();
    wr(8'h90, 32'h6666_0001); wr(8'h94, 32'h6666_0002); idle();
    chk("R6 uncommitted hidden", {63'd0, i_valid}, 0);
    chk("R11 no arb before commit", {63'd0, arb_req}, 0);
    wr(8'h9C, 32'h6666_0003); idle();
    chk("R11 arb after clear", {63'd0, arb_req}, 1);
    chk("R6 commit visible", {63'd0, i_valid}, 1);
    @(negedge clk); #1 chk("R11 arb one cycle", {63'd0, arb_req}, 0);
    pop_i("R6 iso first", 1'b1, 32'h6666_0001);
    pop_i("R6 iso mid", 1'b0, 32'h6666_0002);
    pop_i("R6 iso seal", 1'b0, 32'h6666_0003);
    wr(8'h90, 32'h6666_0004); wr(8'h9C, 32'h6666_0005); idle();
    chk("R11 arb after drain", {63'd0, arb_req}, 1);
    wr(8'h90, 32'h6666_0006); wr(8'h9C, 32'h6666_0007); idle();
    chk("R11 no arb when loaded", {63'd0, arb_req}, 0);
    pop_i("R6 iso pkt", 1'b1, 32'h6666_0004);
    pop_i("R6 iso pkt", 1'b0, 32'h6666_0005);
    pop_i("R6 iso pkt", 1'b1, 32'h6666_0006);
    pop_i("R6 iso pkt", 1'b0, 32'h6666_0007);
    chk("R7 no fault", {63'd0, i_bad}, 0);
  endtask

  task automatic t_iso_underflow();
    wr(8'h90, 32'h7777_0001); wr(8'h9C, 32'h7777_0002); wr(8'h94, 32'h7777_0003); idle();
    pop_i("R8 pre", 1'b1, 32'h7777_0001);
    pop_i("R8 pre", 1'b0, 32'h7777_0002);
    @(negedge clk); i_ready = 1'b1; @(posedge clk); #1 i_ready = 1'b0;
    @(negedge clk); #1;
    chk("R8 underflow faults", {63'd0, i_bad}, 1);
    chk("R8 irq pulse", {63'd0, i_bad_irq}, 1);
    wr(8'h9C, 32'h7777_0004); idle();
    chk("R9 blocked after commit", {63'd0, i_valid}, 0);
    @(negedge clk); clr_iso = 1'b1;
    @(negedge clk); clr_iso = 1'b0; #1;
    chk("R10 clear after underflow", {63'd0, i_bad}, 0);
  endtask

  task automatic t_full();
    wr(8'h80, 32'd100);
    for (int k = 1; k < 32; k++) wr(8'h84, 32'd100 + 32'(k));
    wr(8'h8C, 32'd999); idle();
    chk("R12 commit on full", {63'd0, a_valid}, 1);
    for (int k = 0; k < 32; k++) pop_a("R12 kept", (k == 0), 32'd100 + 32'(k));
    #1 chk("R12 overflow dropped", {63'd0, a_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_async_seal();
    t_async_burst();
    t_async_underflow();
    t_iso_misfirst();
    t_iso_basic();
    t_iso_underflow();
    t_full();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule